// File: doc/BRIEF.md
# Pipelined Triangular Loop Index Decoder

This block is the control automaton for a two-level loop nest over a triangle: the outer index `i` runs from 0 to N−1 and the inner index `j` runs from 0 up to and including `i`. A start pulse captures N. A plain rank counter then issues the ranks 0 … N(N+1)/2 − 1, one per cycle. A chain of registered conditional-subtract stages turns each rank into its (i, j) pair.

Each rank is decoded on its own. No stage reads the previous output pair, so the chain has no feedback path and can be as deep as timing needs. The first `IDX_W` stages resolve `i` from its most significant bit down. Each of these stages subtracts the closed-form growth of the triangular count i(i+1)/2 when the trial bit is set. The next `IDX_W` stages resolve `j` from the leftover residual by subtracting powers of two. When a valid pair leaves the chain, its residual is zero.

A `done` flag reports that the last pair has left the chain. A new sweep can only begin from that idle state.

Top module: `tri_loop_decoder`

## Requirements
- R1: After reset, `out_valid`, `done`, `out_i` and `out_j` are all 0. `done` stays 0 until a start has been accepted.
- R2: A start that is accepted with N on `n_rows` presents every point exactly once, in the order (0,0), (1,0), (1,1), (2,0), … up to (N−1,N−1). The outer index `i` changes slowest and `j` runs from 0 to `i`. Each pair leaves the chain with a zero residual.
- R3: Once the sweep starts, `out_valid` stays high for exactly N(N+1)/2 consecutive cycles, with no gap, so one point is delivered per cycle.
- R4: The latency is fixed. `out_valid` first rises on the 2·`IDX_W`-th rising edge after the edge that accepts start. With the default `IDX_W` = 8, that is the 16th edge.
- R5: `done` is 0 while a sweep is in flight. It becomes 1 in the cycle after the last valid point and stays 1 until a new start is accepted.
- R6: N = 0 produces no valid point. `done` is 1 right after the edge that accepts start.
- R7: A value of N above 2^`IDX_W` is treated as 2^`IDX_W`.
- R8: A start pulse is ignored while the counter is running or any stage still holds a valid rank. Whatever `n_rows` carries at that time has no effect on the sweep in progress.
- R9: Whenever `out_valid` is 1, `out_j` ≤ `out_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Sweep request; accepted only when the block is idle |
| n_rows | input | IDX_W+1 | Row count N, sampled at an accepted start |
| out_i | output | IDX_W | Outer index of the presented point |
| out_j | output | IDX_W | Inner index of the presented point |
| out_valid | output | 1 | The pair on `out_i`/`out_j` is a valid point |
| done | output | 1 | The last sweep has fully drained |

## Verification
Some properties are checked by assertions on every cycle:
- Consecutive valid pairs follow lexicographic order.
- `out_j` never exceeds `out_i`.
- Every stage's residual stays non-negative.
- Every decided index bit is written only once.
- The residual is zero at the output.
- The rank counter steps by exactly one.
- `done` and `out_valid` are never high together.

Other behaviours show only over a whole bench scenario:
- The total point count and the absence of gaps.
- The exact latency from start to the first point.
- The cycle in which `done` rises.
- Clamping of N above the maximum.
- Starts made during the run and during the drain being ignored.

// File: rtl/tri_dec_pkg.sv
package tri_dec_pkg;

  // Number of points in a triangle with n rows: n(n+1)/2.
  function automatic logic [31:0] tri_points(input logic [31:0] n);
    logic [31:0] prod;
    prod = n * (n + 32'd1);
    return prod >> 1;
  endfunction

  // Row count after clamping to the largest supported value.
  function automatic logic [31:0] clamp_rows(input logic [31:0] n, input logic [31:0] nmax);
    return (n > nmax) ? nmax : n;
  endfunction

endpackage

// File: rtl/tri_rank_counter.sv
module tri_rank_counter #(
  parameter int IDX_W  = 8,
  parameter int NW     = IDX_W + 1,
  parameter int RANK_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic [NW-1:0]     n_in,
  output logic              rank_v,
  output logic [RANK_W-1:0] rank
);
  localparam logic [31:0] NMAX = 32'd1 << IDX_W;

  logic              active;
  logic [RANK_W-1:0] last;
  logic [31:0]       n_eff;
  logic [31:0]       pts;
  logic              at_last;

  always_comb begin
    n_eff = tri_dec_pkg::clamp_rows(32'(n_in), NMAX);
    pts   = tri_dec_pkg::tri_points(n_eff);
  end

  assign at_last = (rank == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      rank   <= '0;
      last   <= '0;
    end else if (start_ok) begin
      rank   <= '0;
      last   <= RANK_W'(pts - 32'd1);
      active <= (pts != 32'd0);
    end else if (active) begin
      if (at_last) active <= 1'b0;
      else         rank   <= rank + 1'b1;
    end
  end

  assign rank_v = active;

  // R3: a running counter advances by exactly one rank per cycle.
  assert_rank_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !at_last && !start_ok) |=> (active && rank == $past(rank) + 1'b1));

endmodule

// File: rtl/tri_bit_stage.sv
module tri_bit_stage #(
  parameter int IDX_W = 8,
  parameter int DW    = 2 * IDX_W + 2,
  parameter int LVL   = 0,
  parameter bit ROW   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_v,
  input  logic signed [DW-1:0] in_res,
  input  logic [IDX_W-1:0]     in_i,
  input  logic [IDX_W-1:0]     in_j,
  output logic                 out_v,
  output logic signed [DW-1:0] out_res,
  output logic [IDX_W-1:0]     out_i,
  output logic [IDX_W-1:0]     out_j
);
  // Growth of i(i+1)/2 when bit LVL of i is set, without the i-dependent part.
  localparam int unsigned HALF = ((1 << LVL) * ((1 << LVL) + 1)) / 2;

  function automatic logic signed [DW-1:0] row_step(input logic [IDX_W-1:0] hi);
    logic [DW-1:0] scaled;
    scaled = DW'(hi) << LVL;
    return $signed(scaled + DW'(HALF));
  endfunction

  function automatic logic signed [DW-1:0] col_step();
    return $signed(DW'(1) << LVL);
  endfunction

  logic signed [DW-1:0] step;
  logic signed [DW-1:0] trial;
  logic                 take;
  logic [IDX_W-1:0]     cur_idx;

  always_comb begin
    step    = ROW ? row_step(in_i) : col_step();
    trial   = in_res - step;
    take    = in_v && !trial[DW-1];
    cur_idx = ROW ? in_i : in_j;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v   <= 1'b0;
      out_res <= '0;
      out_i   <= '0;
      out_j   <= '0;
    end else begin
      out_v   <= in_v;
      out_res <= take ? trial : in_res;
      out_i   <= in_i;
      out_j   <= in_j;
      if (take) begin
        if (ROW) out_i[LVL] <= 1'b1;
        else     out_j[LVL] <= 1'b1;
      end
    end
  end

  // R2: a valid residual never goes negative between stages.
  assert_residual_nonneg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_v |-> !out_res[DW-1]);

  // R2: the bit this stage decides has not yet been set by an earlier stage.
  assert_bit_undecided_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_v |-> !cur_idx[LVL]);

endmodule

// File: rtl/tri_index_pipe.sv
module tri_index_pipe #(
  parameter int IDX_W  = 8,
  parameter int RANK_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v,
  input  logic [RANK_W-1:0] in_rank,
  output logic              out_v,
  output logic [IDX_W-1:0]  out_i,
  output logic [IDX_W-1:0]  out_j,
  output logic              busy
);
  localparam int NST = 2 * IDX_W;
  localparam int DW  = RANK_W + 2;

  logic [NST:0]         v;
  logic signed [DW-1:0] res [0:NST];
  logic [IDX_W-1:0]     ii  [0:NST];
  logic [IDX_W-1:0]     jj  [0:NST];

  assign v[0]   = in_v;
  assign res[0] = $signed({2'b00, in_rank});
  assign ii[0]  = '0;
  assign jj[0]  = '0;

  for (genvar s = 0; s < NST; s++) begin : g_stage
    if (s < IDX_W) begin : g_row
      tri_bit_stage #(.IDX_W(IDX_W), .DW(DW), .LVL(IDX_W - 1 - s), .ROW(1'b1)) u_st (
        .clk(clk), .rst_n(rst_n),
        .in_v(v[s]), .in_res(res[s]), .in_i(ii[s]), .in_j(jj[s]),
        .out_v(v[s+1]), .out_res(res[s+1]), .out_i(ii[s+1]), .out_j(jj[s+1]));
    end else begin : g_col
      tri_bit_stage #(.IDX_W(IDX_W), .DW(DW), .LVL(NST - 1 - s), .ROW(1'b0)) u_st (
        .clk(clk), .rst_n(rst_n),
        .in_v(v[s]), .in_res(res[s]), .in_i(ii[s]), .in_j(jj[s]),
        .out_v(v[s+1]), .out_res(res[s+1]), .out_i(ii[s+1]), .out_j(jj[s+1]));
    end
  end

  assign out_v = v[NST];
  assign out_i = ii[NST];
  assign out_j = jj[NST];
  assign busy  = |v[NST:1];

  // R2: an exactly inverted rank leaves no residual.
  assert_exact_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    v[NST] |-> (res[NST] == '0));

endmodule

// File: rtl/tri_loop_decoder.sv
module tri_loop_decoder #(
  parameter int IDX_W = 8,
  parameter int NW    = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NW-1:0]    n_rows,
  output logic [IDX_W-1:0] out_i,
  output logic [IDX_W-1:0] out_j,
  output logic             out_valid,
  output logic             done
);
  localparam int RANK_W = 2 * IDX_W;

  logic              cnt_v;
  logic [RANK_W-1:0] cnt_rank;
  logic              pipe_busy;
  logic              busy;
  logic              start_ok;
  logic              ran_q;

  assign busy     = cnt_v | pipe_busy;
  assign start_ok = start & ~busy;

  tri_rank_counter #(.IDX_W(IDX_W), .NW(NW), .RANK_W(RANK_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .n_in(n_rows),
    .rank_v(cnt_v), .rank(cnt_rank));

  tri_index_pipe #(.IDX_W(IDX_W), .RANK_W(RANK_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_v(cnt_v), .in_rank(cnt_rank),
    .out_v(out_valid), .out_i(out_i), .out_j(out_j), .busy(pipe_busy));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ran_q <= 1'b0;
    else if (start_ok) ran_q <= 1'b1;
  end

  assign done = ran_q & ~busy;

  // R5: done never coincides with a presented point.
  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);

  // R9: the inner index never exceeds the outer one.
  assert_j_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_j <= out_i));

  // R2: back-to-back points are lexicographic successors.
  assert_lex_successor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |->
      ((out_i == $past(out_i) && out_j == $past(out_j) + 1'b1) ||
       (out_j == '0 && $past(out_j) == $past(out_i) && out_i == $past(out_i) + 1'b1)));

endmodule

// File: tb/test_tri_loop_decoder.sv
module test_tri_loop_decoder;
  localparam int IDX_W      = 8;
  localparam int NW         = IDX_W + 1;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2 * IDX_W + 1;  // sample index of first point

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [NW-1:0]    n_rows = '0;
  logic [IDX_W-1:0] out_i, out_j;
  logic             out_valid, done;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tri_loop_decoder #(.IDX_W(IDX_W), .NW(NW)) i_tri_loop_decoder (
    .clk(clk), .rst_n(rst_n), .start(start), .n_rows(n_rows),
    .out_i(out_i), .out_j(out_j), .out_valid(out_valid), .done(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One sweep: drive N, optionally poke start again at sample poke_at.
  task automatic sweep(input int n_drive, input int n_exp, input int poke_at, input int poke_n);
    int total = n_exp * (n_exp + 1) / 2;
    int ei = 0, ej = 0, seen = 0, first_k = -1, done_k = -1;
    bit ended = 1'b0, gap = 1'b0;
    @(negedge clk);
    n_rows = NW'(n_drive);
    start  = 1'b1;
    for (int k = 1; k <= total + LAT + 50; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == poke_at) begin
        start  = 1'b1;
        n_rows = NW'(poke_n);
      end
      if (out_valid) begin
        if (first_k < 0) first_k = k;
        if (ended) gap = 1'b1;
        chk(int'(out_i) == ei && int'(out_j) == ej, "R2 point (i*1000+j)",
            int'(out_i) * 1000 + int'(out_j), ei * 1000 + ej);
        chk(out_j <= out_i, "R9 j not above i", int'(out_j), int'(out_i));
        chk(!done, "R5 done low during sweep", int'(done), 0);
        seen++;
        ej++;
        if (ej > ei) begin
          ei++;
          ej = 0;
        end
      end else if (seen > 0) begin
        ended = 1'b1;
      end
      if (done) begin
        done_k = k;
        break;
      end
    end
    chk(done_k > 0, "R5 done reached", done_k, 1);
    chk(seen == total, "R2 point count", seen, total);
    chk(!gap, "R3 no gap in valid", int'(gap), 0);
    if (total > 0) begin
      chk(first_k == LAT, "R4 latency to first point", first_k, LAT);
      chk(done_k == LAT + total, "R5 done after last point", done_k, LAT + total);
    end else begin
      chk(first_k < 0, "R6 no point for N=0", first_k, -1);
      chk(done_k == 1, "R6 done right after start", done_k, 1);
    end
    @(negedge clk);
    chk(done && !out_valid, "R5 done held while idle", int'(done), 1);
  endtask

  task automatic reset_test();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 valid in reset", int'(out_valid), 0);
    chk(!done, "R1 done in reset", int'(done), 0);
    chk(out_i == '0 && out_j == '0, "R1 indices in reset", int'(out_i) + int'(out_j), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !out_valid, "R1 idle without start", int'(done), 0);
  endtask

  initial begin
    reset_test();
    sweep(1, 1, 0, 0);          // R2 single point
    sweep(2, 2, 0, 0);          // R2 R3
    sweep(5, 5, 3, 9);          // R8 start during counting ignored
    sweep(4, 4, 20, 7);         // R8 start during drain ignored
    sweep(0, 0, 0, 0);          // R6
    sweep(17, 17, 0, 0);        // R2 R3 R4
    sweep(300, 256, 0, 0);      // R7 clamp to full range
    sweep(3, 3, 0, 0);          // R5 restart after done
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule